// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Tags

This block is the receive-side character queue of a serial port. The receiver pushes each character into it together with three error tags: a framing error, a parity error and a break indication. The host pops characters by reading the receive register. The queue keeps the tags next to each stored character, so the status seen by the host always belongs to the character it is about to read.

Two kinds of status are produced. The first is head status: the data and the three tags of the character at the front of the queue. It changes as soon as a pop moves a new character to the front, and it reads all zero when the queue is empty. The second is a summary bit that is high while any stored character, at any position, carries an error. A running count of errored entries drives this bit: a push of an errored character increments the count and a pop of one decrements it. The bit therefore drops only when the last errored character has left.

The queue also reports its fill level, empty and full. A push into a full queue is dropped and produces a one-cycle overflow pulse. A pop from an empty queue is ignored. A push and a pop in the same cycle both complete in that cycle, and this includes the case where the queue is full.

Top module: `rxq_fifo`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the queue empties. After that edge `empty_o`=1, `full_o`=0, `level_o`=0, `err_any_o`=0 and `overflow_o`=0.
- R2: Characters leave in the order they were accepted. `rd_data_o` shows the data of the front character whenever the queue is not empty.
- R3: `head_fe_o`, `head_pe_o` and `head_bi_o` equal the framing, parity and break tags pushed with the front character. After a pop they show the tags of the new front character, with no extra cycle of delay.
- R4: When the queue is empty, `rd_data_o`, `head_fe_o`, `head_pe_o` and `head_bi_o` are all zero.
- R5: `err_any_o` is 1 in the cycle after a push that stores a character with at least one tag set. It stays 1 while any such character is stored.
- R6: `err_any_o` falls only when a pop removes the last stored character that has a tag set.
- R7: `level_o` counts the stored characters, from 0 up to DEPTH (default 64). `full_o` is 1 exactly at DEPTH and `empty_o` is 1 exactly at 0.
- R8: A push while the queue is full and no pop happens is dropped and leaves the contents unchanged. `overflow_o` is 1 for the cycle after that edge only.
- R9: A pop while the queue is empty is ignored: the level stays 0 and no state changes.
- R10: A push and a pop in the same cycle on a non-empty queue both take effect. The level is unchanged, and this holds even when the queue is full, where the push is accepted.
- R11: Asserting `rst` while the queue is partly filled discards all contents, including errored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push a character from the receiver |
| push_data_i | input | DATA_W | Character to push |
| push_fe_i | input | 1 | Framing error tag of the pushed character |
| push_pe_i | input | 1 | Parity error tag of the pushed character |
| push_bi_i | input | 1 | Break tag of the pushed character |
| pop_i | input | 1 | Host read of the receive register |
| rd_data_o | output | DATA_W | Data of the front character |
| head_fe_o | output | 1 | Framing error tag of the front character |
| head_pe_o | output | 1 | Parity error tag of the front character |
| head_bi_o | output | 1 | Break tag of the front character |
| err_any_o | output | 1 | Some stored character carries an error tag |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| level_o | output | $clog2(DEPTH+1) | Number of stored characters |
| overflow_o | output | 1 | One-cycle pulse after a dropped push |

## Verification
Every result is due one clock edge after its stimulus. Level, empty, full and the error summary come straight from registers. Head data and tags are decoded combinationally from the registered read pointer. The overflow pulse is registered from the push that was dropped. The bench therefore drives inputs on the falling edge and samples all outputs 5 ns after the following rising edge. At that point it compares them with a queue model that it updated for that same edge. The summary bit is predicted by scanning the model's stored tags, not by keeping a counter.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic brk;
        logic par;
        logic frm;
    } rxq_flags_t;

    localparam int FLAG_W = $bits(rxq_flags_t);

    function automatic logic rxq_has_err(input rxq_flags_t f);
        return f.brk | f.par | f.frm;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int ENTRY_W = 11,
    parameter int DEPTH   = 64,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [ENTRY_W-1:0] wr_entry,
    input  logic [AW-1:0]      rd_addr,
    output logic [ENTRY_W-1:0] rd_entry
);

    logic [ENTRY_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_entry;
        end
    end

    always_comb begin
        rd_entry = mem_q[rd_addr];
    end

endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [AW-1:0] wr_ptr_o,
    output logic [AW-1:0] rd_ptr_o,
    output logic [LW-1:0] level_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          push_ok_o,
    output logic          pop_ok_o,
    output logic          ovf_o
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [LW-1:0] lvl;
        logic          ovf;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic pop_ok, push_ok;

    always_comb begin
        pop_ok  = pop_i && (st_q.lvl != '0);
        push_ok = push_i && ((st_q.lvl != FULL_LVL) || pop_ok);
        st_d     = st_q;
        st_d.ovf = push_i && !push_ok;
        if (push_ok) begin
            st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
        end
        if (push_ok && !pop_ok) begin
            st_d.lvl = st_q.lvl + 1'b1;
        end else if (pop_ok && !push_ok) begin
            st_d.lvl = st_q.lvl - 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wr_ptr_o  = st_q.wr;
    assign rd_ptr_o  = st_q.rd;
    assign level_o   = st_q.lvl;
    assign empty_o   = (st_q.lvl == '0);
    assign full_o    = (st_q.lvl == FULL_LVL);
    assign push_ok_o = push_ok;
    assign pop_ok_o  = pop_ok;
    assign ovf_o     = st_q.ovf;

    // R7: level never exceeds the capacity
    a_r7_level_bound: assert property (@(posedge clk) disable iff (rst)
        level_o <= FULL_LVL);

    // R9: a lone pop on an empty queue leaves it empty
    a_r9_pop_empty: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && empty_o) |=> empty_o);

    // R10: push and pop together keep the level
    a_r10_level_kept: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && !empty_o) |=> $stable(level_o));

    // R8: a dropped push leaves the queue full
    a_r8_ovf_full: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> full_o);

endmodule

// File: rtl/rxq_errcnt.sv
module rxq_errcnt #(
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc_i,
    input  logic          dec_i,
    input  logic [LW-1:0] level_i,
    output logic          any_o
);

    typedef struct packed {
        logic [LW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc_i && !dec_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (dec_i && !inc_i) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign any_o = (st_q.cnt != '0);

    // R5: errored entries can never outnumber stored entries
    a_r5_cnt_le_level: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= level_i);

    // R6: the summary bit only drops after an errored entry left
    a_r6_fall_on_pop: assert property (@(posedge clk) disable iff (rst)
        $fell(any_o) |-> ($past(dec_i) || $past(rst)));

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW      = $clog2(DEPTH),
    localparam int LW      = $clog2(DEPTH + 1),
    localparam int ENTRY_W = DATA_W + FLAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              push_fe_i,
    input  logic              push_pe_i,
    input  logic              push_bi_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              head_fe_o,
    output logic              head_pe_o,
    output logic              head_bi_o,
    output logic              err_any_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [LW-1:0]     level_o,
    output logic              overflow_o
);

    logic [AW-1:0]      wr_ptr, rd_ptr;
    logic               push_ok, pop_ok;
    logic [ENTRY_W-1:0] wr_entry, rd_entry;
    rxq_flags_t         in_flags, head_flags;
    logic [DATA_W-1:0]  head_data;

    assign in_flags = '{brk: push_bi_i, par: push_pe_i, frm: push_fe_i};
    assign wr_entry = {in_flags, push_data_i};

    rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk       (clk),
        .rst       (rst),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .wr_ptr_o  (wr_ptr),
        .rd_ptr_o  (rd_ptr),
        .level_o   (level_o),
        .empty_o   (empty_o),
        .full_o    (full_o),
        .push_ok_o (push_ok),
        .pop_ok_o  (pop_ok),
        .ovf_o     (overflow_o)
    );

    rxq_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .wr_en    (push_ok),
        .wr_addr  (wr_ptr),
        .wr_entry (wr_entry),
        .rd_addr  (rd_ptr),
        .rd_entry (rd_entry)
    );

    assign head_flags = empty_o ? '0 : rxq_flags_t'(rd_entry[ENTRY_W-1:DATA_W]);
    assign head_data  = empty_o ? '0 : rd_entry[DATA_W-1:0];

    rxq_errcnt #(.LW(LW)) u_errcnt (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (push_ok && rxq_has_err(in_flags)),
        .dec_i   (pop_ok && rxq_has_err(head_flags)),
        .level_i (level_o),
        .any_o   (err_any_o)
    );

    assign rd_data_o = head_data;
    assign head_fe_o = head_flags.frm;
    assign head_pe_o = head_flags.par;
    assign head_bi_o = head_flags.brk;

    // R5: an errored front character implies the summary bit
    a_r5_head_implies_any: assert property (@(posedge clk) disable iff (rst)
        (head_fe_o || head_pe_o || head_bi_o) |-> err_any_o);

    // R4: an empty queue reports no error anywhere
    a_r4_empty_no_err: assert property (@(posedge clk) disable iff (rst)
        empty_o |-> !err_any_o);

    // R7: full and empty are exclusive
    a_r7_not_both: assert property (@(posedge clk) disable iff (rst)
        !(empty_o && full_o));

endmodule

// File: tb/rxq_fifo_test.sv
module rxq_fifo_test;

    localparam int DEPTH = 64;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic push = 1'b0, pop = 1'b0;
    logic [7:0] pdata = '0;
    logic pfe = 1'b0, ppe = 1'b0, pbi = 1'b0;
    logic [7:0] rd_data;
    logic hfe, hpe, hbi, err_any, empty, full, ovf;
    logic [LW-1:0] level;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [10:0] mq[$];
    bit e_ovf = 1'b0;

    always #10 clk = ~clk;

    rxq_fifo #(.DATA_W(8), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .push_i(push), .push_data_i(pdata),
        .push_fe_i(pfe), .push_pe_i(ppe), .push_bi_i(pbi), .pop_i(pop),
        .rd_data_o(rd_data), .head_fe_o(hfe), .head_pe_o(hpe), .head_bi_o(hbi),
        .err_any_o(err_any), .empty_o(empty), .full_o(full),
        .level_o(level), .overflow_o(ovf)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic bit model_err_any();
        foreach (mq[i]) if (mq[i][10:8] != 3'b000) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_all();
        logic [10:0] h;
        h = (mq.size() > 0) ? mq[0] : 11'h0;
        chk(int'(level) == mq.size(), "R7 level", int'(level), mq.size());
        chk(empty == (mq.size() == 0), "R7 empty", empty, mq.size() == 0);
        chk(full == (mq.size() == DEPTH), "R7 full", full, mq.size() == DEPTH);
        chk(rd_data == h[7:0], "R2/R4 head data", rd_data, h[7:0]);
        chk({hbi, hpe, hfe} == h[10:8], "R3/R4 head tags", {hbi, hpe, hfe}, h[10:8]);
        chk(err_any == model_err_any(), "R5/R6 err_any", err_any, model_err_any());
        chk(ovf == e_ovf, "R8 overflow", ovf, e_ovf);
    endtask

    task automatic step(input bit pu, input bit po, input logic [7:0] d, input logic [2:0] f);
        int sz;
        bit pop_ok, push_ok;
        @(negedge clk);
        push = pu; pop = po; pdata = d; {pbi, ppe, pfe} = f;
        sz = mq.size();
        pop_ok = po && sz > 0;
        push_ok = pu && (sz < DEPTH || pop_ok);
        @(posedge clk);
        #5;
        e_ovf = pu && !push_ok;
        if (pop_ok) void'(mq.pop_front());
        if (push_ok) mq.push_back({f, d});
        check_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; push = 1'b0; pop = 1'b0;
        @(posedge clk);
        #5;
        mq.delete();
        e_ovf = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        // R1: reset state
        check_all();
        chk(empty && !err_any && !ovf && level == 0, "R1 reset state", int'(level), 0);

        // R9: pop on empty
        step(1'b0, 1'b1, 8'h00, 3'b000);
        chk(empty == 1'b1, "R9 pop empty ignored", empty, 1);

        // R3, R5: push clean then errored, pop clean -> head shows error
        step(1'b1, 1'b0, 8'h11, 3'b000);
        step(1'b1, 1'b0, 8'h22, 3'b001);
        chk(err_any == 1'b1, "R5 error stored", err_any, 1);
        step(1'b0, 1'b1, 8'h00, 3'b000);
        chk(hfe == 1'b1 && rd_data == 8'h22, "R3 new head tags", {hbi, hpe, hfe}, 1);
        step(1'b0, 1'b1, 8'h00, 3'b000);
        chk(err_any == 1'b0, "R6 last error left", err_any, 0);

        // fill to full with mixed tags
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, 8'(i + 8'h40), (i % 9 == 4) ? 3'(1 + i % 7) : 3'b000);
        end
        chk(full == 1'b1, "R7 full at depth", full, 1);
        // R8: push while full
        step(1'b1, 1'b0, 8'hEE, 3'b111);
        chk(ovf == 1'b1, "R8 overflow pulse", ovf, 1);
        step(1'b0, 1'b0, 8'h00, 3'b000);
        chk(ovf == 1'b0, "R8 pulse one cycle", ovf, 0);
        // R10: push and pop while full
        step(1'b1, 1'b1, 8'hA5, 3'b100);
        chk(full == 1'b1, "R10 full push+pop", full, 1);
        // drain
        for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b1, 8'h00, 3'b000);
        chk(empty && !err_any, "R6 drained", err_any, 0);

        // R11: mid-run reset with errored content
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 8'(i), 3'b010);
        do_reset();
        check_all();
        chk(empty && !err_any, "R11 reset discards", int'(level), 0);

        // random phases
        for (int ph = 0; ph < 40; ph++) begin
            int bias = (ph % 2 == 0) ? 80 : 25;
            for (int k = 0; k < 150; k++) begin
                bit pu = ($urandom_range(99) < bias);
                bit po = ($urandom_range(99) < 50);
                logic [2:0] f = ($urandom_range(3) == 0) ? 3'($urandom_range(7)) : 3'b000;
                step(pu, po, 8'($urandom_range(255)), f);
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule